// File: doc/BRIEF.md
# Indexed Audio Codec Register Port

This block is the host-facing register front end of an audio codec. The host sees four byte-wide registers at consecutive offsets: a selector, a data window, a status byte and a sample byte. The selector picks one register out of a bank of 16 or 32 internal configuration registers, and the data window reads or writes that register. The bank size is a parameter. With a 16-entry bank, selector values 16 to 31 fold onto 0 to 15.

After reset the codec stays busy for a fixed number of clock cycles. A software power-down input holds it busy as well. While the codec is busy, the data window ignores writes and reads back 0x80. The sample-format registers and the interface-configuration register are guarded: they change only while a mode-change bit in the selector is set. The two enable bits of the interface register are the exception and stay writable at any time. While the mode-change bit is set, the converter output is held muted.

Event strobes from the sample datapath set the ready, error and interrupt flags in the status byte. Any write to the status byte clears the interrupt. A transfer-stop bit in the selector can block the DMA request outputs while the interrupt is pending.

Top module: `codec_regport`

## Requirements
- R1: Reading offset 0 returns {busy, mode-change bit, transfer-stop bit, 5-bit selector} from bit 7 down. A write to offset 0 stores bits 6:0, and bit 7 is read-only. After reset all three writable fields read 0.
- R2: `busy` is 1 for INIT_CYCLES clock cycles after reset is released, and it is also 1 whenever `pwr_down` is high. While busy, reading offset 1 returns 0x80 and writes to offset 1 change no register.
- R3: When not busy, a write to offset 1 stores the byte in the register chosen by the selector, and reading offset 1 returns that register. With a 16-entry bank the selector is taken modulo 16.
- R4: Registers 8, 9 and 28 (28 only in a 32-entry bank) change only while the mode-change bit is set. A blocked write leaves them unchanged. The exception is bits 1:0 of register 9, which are written at any time.
- R5: `play_en` equals bit 0 of register 9, and `cap_en` equals bit 1 of register 9.
- R6: `dac_mute` is 1 while the mode-change bit is set or bit 7 of register 6 is set.
- R7: The status byte is, from bit 7 down: capture upper/lower, capture left/right, capture ready, sample error, playback upper/lower, playback left/right, playback ready, interrupt. `cap_rdy_evt` sets capture ready, and a read of offset 3 clears it. `play_rdy_evt` sets playback ready, and a write of offset 3 clears it.
- R8: A write of any value to offset 2 clears the interrupt and sample-error flags. An `irq_evt` or `err_evt` in the same cycle wins, so the flag stays set.
- R9: `play_dreq` = `play_en` & `play_dma_want` and `cap_dreq` = `cap_en` & `cap_dma_want`, except that both are 0 while the transfer-stop bit and the interrupt are both set.
- R10: Reading offset 3 returns `cap_sample`. A write of offset 3 stores the byte on `play_sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Software power-down, holds the codec busy |
| host_addr | input | 2 | Direct register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (side effects only) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| cap_rdy_evt | input | 1 | Capture sample available strobe |
| play_rdy_evt | input | 1 | Playback slot free strobe |
| err_evt | input | 1 | Overrun/underrun strobe |
| irq_evt | input | 1 | Interrupt request strobe |
| cap_upper | input | 1 | Capture upper/lower phase |
| cap_left | input | 1 | Capture left/right phase |
| play_upper | input | 1 | Playback upper/lower phase |
| play_left | input | 1 | Playback left/right phase |
| cap_sample | input | 8 | Byte returned at offset 3 |
| play_dma_want | input | 1 | Playback DMA demand |
| cap_dma_want | input | 1 | Capture DMA demand |
| play_sample | output | 8 | Last byte written at offset 3 |
| play_en | output | 1 | Playback enable |
| cap_en | output | 1 | Capture enable |
| dac_mute | output | 1 | Converter output mute |
| play_dreq | output | 1 | Playback DMA request |
| cap_dreq | output | 1 | Capture DMA request |

## Verification
The status write that clears the interrupt and a new interrupt strobe can land in the same cycle. The bench drives `irq_evt` and a write to offset 2 on the same edge, then reads the status byte. The interrupt bit must still be 1, and a plain status write afterwards must clear it. The same collision decides the DMA gate, so the bench reads `play_dreq` on each side of both events while the transfer-stop bit is set.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;

    localparam logic [1:0] OFS_SEL    = 2'd0;
    localparam logic [1:0] OFS_DATA   = 2'd1;
    localparam logic [1:0] OFS_STATUS = 2'd2;
    localparam logic [1:0] OFS_SAMPLE = 2'd3;

    localparam logic [7:0] BUSY_READBACK = 8'h80;

    localparam int unsigned FMT_REG_A  = 8;
    localparam int unsigned IFACE_REG  = 9;
    localparam int unsigned FMT_REG_B  = 28;
    localparam int unsigned VOL_REG    = 6;

    typedef struct packed {
        logic       mce;
        logic       trd;
        logic [4:0] sel;
    } selector_t;

    typedef struct packed {
        logic cap_upper;
        logic cap_left;
        logic cap_ready;
        logic sample_err;
        logic play_upper;
        logic play_left;
        logic play_ready;
        logic irq;
    } status_t;

    function automatic logic is_guarded(input logic [4:0] eff, input int unsigned count);
        return (eff == 5'(FMT_REG_A)) || (eff == 5'(IFACE_REG)) ||
               ((count > FMT_REG_B) && (eff == 5'(FMT_REG_B)));
    endfunction

endpackage

// File: rtl/crp_init_timer.sv
module crp_init_timer #(
    parameter int unsigned INIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    output logic busy
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          init_busy;

    assign init_busy = (cnt_q != CW'(INIT_CYCLES));
    assign busy      = init_busy | pwr_down;

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (init_busy) cnt_q <= cnt_q + 1'b1;
    end

    // R2: once initialisation has ended it never restarts without reset
    p_init_once_r2: assert property (@(posedge clk) disable iff (rst)
        !init_busy |=> !init_busy);
endmodule

// File: rtl/crp_indirect_bank.sv
module crp_indirect_bank
    import codec_regport_pkg::*;
#(
    parameter int unsigned REG_COUNT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic       mce,
    input  logic [4:0] sel,
    input  logic       data_we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] iface_reg,
    output logic [7:0] vol_reg
);
    localparam int unsigned AW = $clog2(REG_COUNT);
    localparam logic [4:0]  SEL_MASK = 5'(REG_COUNT - 1);

    logic [REG_COUNT-1:0][7:0] mem_q;
    logic [4:0]                eff;
    logic                      guarded;
    logic                      accept;

    assign eff     = sel & SEL_MASK;
    assign guarded = is_guarded(eff, REG_COUNT);
    assign accept  = data_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (accept) begin
            if (!guarded || mce)
                mem_q[eff[AW-1:0]] <= wdata;
            else if (eff == 5'(IFACE_REG))
                mem_q[eff[AW-1:0]][1:0] <= wdata[1:0];
        end
    end

    assign rdata     = mem_q[eff[AW-1:0]];
    assign iface_reg = mem_q[IFACE_REG];
    assign vol_reg   = mem_q[VOL_REG];

    // R2: a busy codec keeps the whole bank
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && data_we) |=> $stable(mem_q));

    // R4: format register untouched without the mode-change bit
    p_fmt_guard_r4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !mce && eff == 5'(FMT_REG_A)) |=> $stable(mem_q[FMT_REG_A]));

    // R4: only the enable bits of the interface register move without it
    p_iface_guard_r4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !mce && eff == 5'(IFACE_REG)) |=> $stable(mem_q[IFACE_REG][7:2]));
endmodule

// File: rtl/crp_status_unit.sv
module crp_status_unit
    import codec_regport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    status_we,
    input  logic    sample_rd,
    input  logic    sample_we,
    input  logic    cap_rdy_evt,
    input  logic    play_rdy_evt,
    input  logic    err_evt,
    input  logic    irq_evt,
    input  logic    cap_upper,
    input  logic    cap_left,
    input  logic    play_upper,
    input  logic    play_left,
    output status_t status
);
    logic cap_rdy_q, play_rdy_q, err_q, irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_rdy_q  <= 1'b0;
            play_rdy_q <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (cap_rdy_evt)    cap_rdy_q  <= 1'b1;
            else if (sample_rd) cap_rdy_q  <= 1'b0;
            if (play_rdy_evt)   play_rdy_q <= 1'b1;
            else if (sample_we) play_rdy_q <= 1'b0;
            if (err_evt)        err_q      <= 1'b1;
            else if (status_we) err_q      <= 1'b0;
            if (irq_evt)        irq_q      <= 1'b1;
            else if (status_we) irq_q      <= 1'b0;
        end
    end

    always_comb begin
        status            = '0;
        status.cap_upper  = cap_upper;
        status.cap_left   = cap_left;
        status.cap_ready  = cap_rdy_q;
        status.sample_err = err_q;
        status.play_upper = play_upper;
        status.play_left  = play_left;
        status.play_ready = play_rdy_q;
        status.irq        = irq_q;
    end

    // R8: a status write with no new request leaves the interrupt clear
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (status_we && !irq_evt) |=> !status.irq);

    // R8: a request is never lost, even against a clearing write
    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        irq_evt |=> status.irq);
endmodule

// File: rtl/codec_regport.sv
module codec_regport
    import codec_regport_pkg::*;
#(
    parameter int unsigned REG_COUNT   = 32,
    parameter int unsigned INIT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_down,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       cap_rdy_evt,
    input  logic       play_rdy_evt,
    input  logic       err_evt,
    input  logic       irq_evt,
    input  logic       cap_upper,
    input  logic       cap_left,
    input  logic       play_upper,
    input  logic       play_left,
    input  logic [7:0] cap_sample,
    input  logic       play_dma_want,
    input  logic       cap_dma_want,
    output logic [7:0] play_sample,
    output logic       play_en,
    output logic       cap_en,
    output logic       dac_mute,
    output logic       play_dreq,
    output logic       cap_dreq
);
    initial begin
        if (REG_COUNT != 16 && REG_COUNT != 32)
            $error("REG_COUNT must be 16 or 32");
    end

    selector_t  sel_q;
    status_t    status;
    logic       busy;
    logic [7:0] bank_rdata, iface_reg, vol_reg;
    logic [7:0] play_sample_q;
    logic       dma_block;

    crp_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q         <= '0;
            play_sample_q <= '0;
        end else if (host_wr) begin
            if (host_addr == OFS_SEL)    sel_q         <= host_wdata[6:0];
            if (host_addr == OFS_SAMPLE) play_sample_q <= host_wdata;
        end
    end

    crp_indirect_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk(clk), .rst(rst), .busy(busy), .mce(sel_q.mce), .sel(sel_q.sel),
        .data_we(host_wr && host_addr == OFS_DATA), .wdata(host_wdata),
        .rdata(bank_rdata), .iface_reg(iface_reg), .vol_reg(vol_reg)
    );

    crp_status_unit u_status (
        .clk(clk), .rst(rst),
        .status_we(host_wr && host_addr == OFS_STATUS),
        .sample_rd(host_rd && host_addr == OFS_SAMPLE),
        .sample_we(host_wr && host_addr == OFS_SAMPLE),
        .cap_rdy_evt(cap_rdy_evt), .play_rdy_evt(play_rdy_evt),
        .err_evt(err_evt), .irq_evt(irq_evt),
        .cap_upper(cap_upper), .cap_left(cap_left),
        .play_upper(play_upper), .play_left(play_left),
        .status(status)
    );

    always_comb begin
        unique case (host_addr)
            OFS_SEL:    host_rdata = {busy, sel_q};
            OFS_DATA:   host_rdata = busy ? BUSY_READBACK : bank_rdata;
            OFS_STATUS: host_rdata = status;
            default:    host_rdata = cap_sample;
        endcase
    end

    assign play_sample = play_sample_q;
    assign play_en     = iface_reg[0];
    assign cap_en      = iface_reg[1];
    assign dac_mute    = sel_q.mce | vol_reg[7];
    assign dma_block   = sel_q.trd & status.irq;
    assign play_dreq   = play_en & play_dma_want & ~dma_block;
    assign cap_dreq    = cap_en & cap_dma_want & ~dma_block;

    // R9: stopped transfers issue no request
    p_trd_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_q.trd && status.irq) |-> (!play_dreq && !cap_dreq));

    // R6: mode change always mutes the converter
    p_mce_mute_r6: assert property (@(posedge clk) disable iff (rst)
        sel_q.mce |-> dac_mute);

    // R2: busy data window reads the fixed pattern
    p_busy_read_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && host_addr == OFS_DATA) |-> host_rdata == BUSY_READBACK);
endmodule

// File: tb/codec_regport_test.sv
module codec_regport_test;
    localparam int INIT = 12;

    logic clk = 0, rst = 1, pwr_down = 0;
    logic [1:0] host_addr = 0;
    logic host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] rdata, rdata16;
    logic cap_rdy_evt = 0, play_rdy_evt = 0, err_evt = 0, irq_evt = 0;
    logic cap_upper = 0, cap_left = 0, play_upper = 0, play_left = 0;
    logic [7:0] cap_sample = 8'hA7;
    logic play_dma_want = 0, cap_dma_want = 0;
    logic [7:0] play_sample, play_sample16;
    logic play_en, cap_en, dac_mute, play_dreq, cap_dreq;
    logic pe16, ce16, dm16, pd16, cd16;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    codec_regport #(.REG_COUNT(32), .INIT_CYCLES(INIT)) uut (
        .clk, .rst, .pwr_down, .host_addr, .host_wr, .host_rd, .host_wdata,
        .host_rdata(rdata), .cap_rdy_evt, .play_rdy_evt, .err_evt, .irq_evt,
        .cap_upper, .cap_left, .play_upper, .play_left, .cap_sample,
        .play_dma_want, .cap_dma_want, .play_sample, .play_en, .cap_en,
        .dac_mute, .play_dreq, .cap_dreq
    );

    codec_regport #(.REG_COUNT(16), .INIT_CYCLES(INIT)) uut_small (
        .clk, .rst, .pwr_down, .host_addr, .host_wr, .host_rd, .host_wdata,
        .host_rdata(rdata16), .cap_rdy_evt, .play_rdy_evt, .err_evt, .irq_evt,
        .cap_upper, .cap_left, .play_upper, .play_left, .cap_sample,
        .play_dma_want, .cap_dma_want, .play_sample(play_sample16),
        .play_en(pe16), .cap_en(ce16), .dac_mute(dm16),
        .play_dreq(pd16), .cap_dreq(cd16)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1; #1 d = rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic put(input logic [4:0] idx, input logic [7:0] d, input logic mode, input logic trd);
        wr(2'd0, {1'b0, mode, trd, idx});
        wr(2'd1, d);
    endtask

    task automatic get(input logic [4:0] idx, input logic mode, input logic trd, output logic [7:0] d);
        wr(2'd0, {1'b0, mode, trd, idx});
        rd(2'd1, d);
    endtask

    task automatic t_reset_init();
        logic [7:0] v;
        rd(2'd0, v); check("R1 reset selector", v, 8'h80);
        rd(2'd1, v); check("R2 busy readback", v, 8'h80);
        wr(2'd1, 8'h55);
        repeat (INIT + 2) @(negedge clk);
        rd(2'd0, v); check("R2 busy released", v, 8'h00);
        rd(2'd1, v); check("R2 write during init ignored", v, 8'h00);
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R1 bit7 read-only", v, 8'h7F);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        put(5'd3, 8'h5A, 0, 0); put(5'd30, 8'hC3, 0, 0);
        get(5'd3, 0, 0, v);  check("R3 reg3", v, 8'h5A);
        get(5'd30, 0, 0, v); check("R3 reg30", v, 8'hC3);
        put(5'd20, 8'h3C, 0, 0);
        wr(2'd0, 8'h04); @(negedge clk); host_addr = 2'd1; #1;
        check("R3 alias 20->4 in 16-entry bank", rdata16, 8'h3C);
        pwr_down = 1;
        put(5'd3, 8'h11, 0, 0);
        rd(2'd1, v); check("R2 power-down readback", v, 8'h80);
        pwr_down = 0;
        get(5'd3, 0, 0, v); check("R2 power-down write ignored", v, 8'h5A);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        put(5'd8, 8'h9E, 0, 0); get(5'd8, 0, 0, v); check("R4 reg8 blocked", v, 8'h00);
        put(5'd28, 8'h44, 0, 0); get(5'd28, 0, 0, v); check("R4 reg28 blocked", v, 8'h00);
        put(5'd9, 8'hF1, 0, 0); get(5'd9, 0, 0, v); check("R4 reg9 enables only", v, 8'h01);
        @(negedge clk); check("R5 play_en", {6'd0, cap_en, play_en}, 8'h01);
        check("R6 no mute", {7'd0, dac_mute}, 8'h00);
        put(5'd8, 8'h9E, 1, 0);
        #1 check("R6 mute while mode change", {7'd0, dac_mute}, 8'h01);
        get(5'd8, 1, 0, v); check("R4 reg8 written with mce", v, 8'h9E);
        put(5'd9, 8'hF2, 1, 0); get(5'd9, 0, 0, v); check("R4 reg9 with mce", v, 8'hF2);
        @(negedge clk); check("R5 cap_en", {6'd0, cap_en, play_en}, 8'h02);
        put(5'd6, 8'h80, 0, 0); #1 check("R6 reg6 mute", {7'd0, dac_mute}, 8'h01);
        put(5'd6, 8'h00, 0, 0); put(5'd9, 8'h03, 0, 0);
    endtask

    task automatic t_status();
        logic [7:0] v;
        @(negedge clk); cap_upper = 1; play_left = 1; cap_rdy_evt = 1; play_rdy_evt = 1; err_evt = 1;
        @(negedge clk); cap_rdy_evt = 0; play_rdy_evt = 0; err_evt = 0;
        rd(2'd2, v); check("R7 status layout", v, 8'hB6);
        rd(2'd3, v); check("R10 sample read", v, 8'hA7);
        wr(2'd3, 8'h6D); check("R10 sample write", play_sample, 8'h6D);
        rd(2'd2, v); check("R7 ready flags cleared", v, 8'h94);
        // R8 collision: clearing write and new request on one edge
        @(negedge clk); host_addr = 2'd2; host_wr = 1; irq_evt = 1;
        @(negedge clk); host_wr = 0; irq_evt = 0;
        rd(2'd2, v); check("R8 request wins over clear", v, 8'h85);
        wr(2'd2, 8'h00); rd(2'd2, v); check("R8 status write clears", v, 8'h84);
        cap_upper = 0; play_left = 0;
    endtask

    task automatic t_dma();
        @(negedge clk); play_dma_want = 1; cap_dma_want = 1;
        #1 check("R9 requests flow", {6'd0, cap_dreq, play_dreq}, 8'h03);
        @(negedge clk); irq_evt = 1; @(negedge clk); irq_evt = 0;
        check("R9 auto mode ignores irq", {6'd0, cap_dreq, play_dreq}, 8'h03);
        wr(2'd0, 8'h20);
        check("R9 trd blocks", {6'd0, cap_dreq, play_dreq}, 8'h00);
        wr(2'd2, 8'h00);
        check("R9 resumes after clear", {6'd0, cap_dreq, play_dreq}, 8'h03);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk); rst = 0;
                t_reset_init(); t_bank(); t_mode(); t_status(); t_dma();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule